// File: doc/BRIEF.md
# Edge Event Timestamp Capture Unit

This block stamps the transitions of a slow external event line, for example a conditioned mains zero-crossing or a once-per-second pulse. It runs its own time counter made of whole seconds and a nanosecond fraction. It passes the event line through a synchronizer. Each accepted rising transition (the assert edge) and each accepted falling transition (the clear edge) produces a timestamped record.

Assert edges also feed a small statistics stage, which computes three values:
- the period since the previous assert;
- the change of that period from the one before (jitter);
- the signed position of the event relative to the nearest second boundary.

A holdoff window suppresses glitches and limits the event rate. Records wait in a small FIFO and leave through a valid/ready interface. A record that finds the FIFO full is dropped. The sequence numbers still advance, and the next stored record carries a loss marker, so software can see the gap.

Top module: `ets_capture`

## Requirements
- R1: While `rst_n` is low and right after it rises, no record is offered (`rec_valid_o` = 0). The time counter restarts at 0 s / 0 ns. Both sequence counters restart at 0. The statistics history is cleared.
- R2: An accepted rising edge of `evt_i` produces a record with `rec_assert_o` = 1, and an accepted falling edge produces one with `rec_assert_o` = 0. The stamped time is the counter value during the clock cycle in which `evt_i` changed, with the synchronizer delay of `SYNC_STAGES` cycles removed.
- R3: The time counter adds `NS_INC` nanoseconds per clock. When the fraction would reach 1,000,000,000 or more, 1,000,000,000 is subtracted from it and the seconds field increases by one. The fraction always stays below 1,000,000,000.
- R4: Assert and clear records carry separate sequence numbers. Each starts at 0 and increases by one per accepted edge of its polarity, including edges whose record is dropped.
- R5: On an assert record, `rec_delta_o` is the time in nanoseconds since the previous accepted assert, and `rec_delta_ok_o` = 1. On the first assert after reset, and on every clear record, both are 0.
- R6: On an assert record, `rec_jitter_o` is the signed difference between this delta and the previous delta, and `rec_jitter_ok_o` = 1. On the first two asserts after reset, and on every clear record, both are 0.
- R7: `rec_offset_o` is the signed stamped fraction when that fraction is below 500,000,000 ns. Otherwise it is the fraction minus 1,000,000,000.
- R8: After an accepted edge, further edges of the same polarity that arrive within `HOLDOFF` clock cycles produce no record and do not advance counters. An edge `HOLDOFF`+1 cycles later is accepted. The two polarities have independent windows.
- R9: Records leave in the order the edges occurred. While `rec_valid_o` = 1 and `rec_ready_i` = 0, the offered record stays unchanged.
- R10: A record produced while the FIFO holds `FIFO_DEPTH` entries is dropped. The next record that is stored carries `rec_lost_o` = 1. Every other record carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Asynchronous event line |
| rec_ready_i | input | 1 | Consumer accepts the offered record |
| rec_valid_o | output | 1 | A record is offered |
| rec_assert_o | output | 1 | 1 = assert (rising) record, 0 = clear (falling) record |
| rec_seq_o | output | SEQ_W | Per-polarity sequence number |
| rec_sec_o | output | SEC_W | Timestamp whole seconds |
| rec_ns_o | output | 30 | Timestamp nanosecond fraction |
| rec_delta_o | output | DELTA_W | Period since previous assert, ns |
| rec_delta_ok_o | output | 1 | Delta is valid |
| rec_jitter_o | output | JIT_W | Signed change of period, ns |
| rec_jitter_ok_o | output | 1 | Jitter is valid |
| rec_offset_o | output | 32 | Signed offset from nearest second, ns |
| rec_lost_o | output | 1 | At least one record was dropped before this one |

## Verification
The bench targets several corner cases, each tied to a typical mistake:
- **Holdoff boundary.** Same-polarity edges exactly `HOLDOFF` and `HOLDOFF`+1 cycles apart are driven on both polarities. An off-by-one window would either swallow a legitimate edge or emit a glitch record, and the next sequence number or delta would show it.
- **Second boundary.** The timestamps cross second boundaries with an increment that does not divide a second. A wrong carry would show as a fraction at or above one billion or a bad delta across the boundary.
- **Statistics start-up.** The first and second asserts after a mid-run reset are checked, so a design that kept stale history would report a valid delta or jitter too early.
- **Overflow.** The FIFO is filled against a stalled consumer. A design that froze the sequence numbers, broke the delta chain or failed to mark the loss would be caught on the first record after the drain.

// File: rtl/ets_pkg.sv
package ets_pkg;
   localparam int unsigned NS_PER_SEC = 1_000_000_000;
   localparam int          NS_W       = 30;
   localparam int          OFF_W      = 32;

   typedef enum logic {
      EDGE_CLEAR  = 1'b0,
      EDGE_ASSERT = 1'b1
   } edge_kind_e;

   // Signed position of a fraction relative to the nearest second boundary (R7)
   function automatic logic signed [OFF_W-1:0] sec_offset(input logic [NS_W-1:0] frac);
      if (frac >= NS_W'(NS_PER_SEC / 2))
         return $signed(OFF_W'(frac) - OFF_W'(NS_PER_SEC));
      return $signed(OFF_W'(frac));
   endfunction
endpackage

// File: rtl/ets_timebase.sv
module ets_timebase
   import ets_pkg::*;
#(
   parameter int unsigned NS_INC = 10,
   parameter int          SEC_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [SEC_W-1:0] sec_o,
   output logic [NS_W-1:0]  ns_o
);
   localparam logic [NS_W-1:0] INC     = NS_W'(NS_INC);
   localparam logic [NS_W-1:0] WRAP_AT = NS_W'(NS_PER_SEC - NS_INC);

   if (NS_INC == 0 || NS_INC >= NS_PER_SEC) begin : g_bad_inc
      $error("ets_timebase: NS_INC must lie in 1..999999999");
   end

   // R3: fixed increment, carry into seconds at one billion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_o <= '0;
         ns_o  <= '0;
      end else if (ns_o >= WRAP_AT) begin
         ns_o  <= ns_o - WRAP_AT;
         sec_o <= sec_o + SEC_W'(1);
      end else begin
         ns_o  <= ns_o + INC;
      end
   end

   a_r3_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
      ns_o < NS_W'(NS_PER_SEC));

   a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_o != $past(sec_o)) |-> (sec_o == $past(sec_o) + SEC_W'(1)) && (ns_o < INC));
endmodule

// File: rtl/ets_edge_gate.sv
module ets_edge_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLDOFF     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int HO_W = $clog2(HOLDOFF + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ets_edge_gate: SYNC_STAGES must be at least 2");
   end
   if (HOLDOFF < 1) begin : g_bad_hold
      $error("ets_edge_gate: HOLDOFF must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic [1:0]             raw, acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], evt_i};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign raw[1] =  sync_q[SYNC_STAGES-1] & ~last_q;  // rising
   assign raw[0] = ~sync_q[SYNC_STAGES-1] &  last_q;  // falling

   // R8: one independent holdoff window per polarity
   for (genvar p = 0; p < 2; p++) begin : g_pol
      logic [HO_W-1:0] hold_q;
      assign acc[p] = raw[p] && (hold_q == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                hold_q <= '0;
         else if (acc[p])           hold_q <= HO_W'(HOLDOFF);
         else if (hold_q != '0)     hold_q <= hold_q - HO_W'(1);
      end

      a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
         acc[p] |=> !acc[p]);
   end

   assign rise_o = acc[1];
   assign fall_o = acc[0];
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   output logic         full_o,
   output logic         valid_o,
   input  logic         ready_i,
   output logic [W-1:0] data_o
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("ets_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_q, rd_q;

   assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
   assign valid_o = (wr_q != rd_q);
   assign data_o  = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push_i && !full_o) mem[wr_q[AW-1:0]] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push_i && !full_o)   wr_q <= wr_q + (AW+1)'(1);
         if (valid_o && ready_i)  rd_q <= rd_q + (AW+1)'(1);
      end
   end

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/ets_capture.sv
module ets_capture
   import ets_pkg::*;
#(
   parameter int unsigned NS_INC      = 10,
   parameter int          SEC_W       = 32,
   parameter int          SEQ_W       = 16,
   parameter int          DELTA_W     = 40,
   parameter int          JIT_W       = 32,
   parameter int          SYNC_STAGES = 2,
   parameter int          HOLDOFF     = 8,
   parameter int          FIFO_DEPTH  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    evt_i,
   input  logic                    rec_ready_i,
   output logic                    rec_valid_o,
   output logic                    rec_assert_o,
   output logic [SEQ_W-1:0]        rec_seq_o,
   output logic [SEC_W-1:0]        rec_sec_o,
   output logic [NS_W-1:0]         rec_ns_o,
   output logic [DELTA_W-1:0]      rec_delta_o,
   output logic                    rec_delta_ok_o,
   output logic signed [JIT_W-1:0] rec_jitter_o,
   output logic                    rec_jitter_ok_o,
   output logic signed [OFF_W-1:0] rec_offset_o,
   output logic                    rec_lost_o
);
   localparam int unsigned     CORR     = SYNC_STAGES * NS_INC;
   localparam logic [NS_W-1:0] CORR_NS  = NS_W'(CORR);
   localparam logic [NS_W-1:0] CORR_BOR = NS_W'(NS_PER_SEC - CORR);
   localparam int REC_W = 2 + SEQ_W + SEC_W + NS_W + DELTA_W + 1 + JIT_W + 1 + OFF_W;

   if (CORR >= NS_PER_SEC || SEC_W > 32 || DELTA_W > 64 || JIT_W > 64) begin : g_bad_cfg
      $error("ets_capture: unsupported parameter combination");
   end

   logic [SEC_W-1:0] now_sec, cor_sec;
   logic [NS_W-1:0]  now_ns,  cor_ns;
   logic             rise, fall;

   ets_timebase #(.NS_INC(NS_INC), .SEC_W(SEC_W)) u_time (
      .clk(clk), .rst_n(rst_n), .sec_o(now_sec), .ns_o(now_ns));

   ets_edge_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLDOFF(HOLDOFF)) u_gate (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rise_o(rise), .fall_o(fall));

   // R2: remove synchronizer latency, borrowing from seconds when needed
   always_comb begin
      if (now_ns >= CORR_NS) begin
         cor_ns  = now_ns - CORR_NS;
         cor_sec = now_sec;
      end else begin
         cor_ns  = now_ns + CORR_BOR;
         cor_sec = now_sec - SEC_W'(1);
      end
   end

   // Stage 1: latch timestamp and sequence number (R4)
   logic             stg_v;
   edge_kind_e       stg_kind;
   logic [SEC_W-1:0] stg_sec;
   logic [NS_W-1:0]  stg_ns;
   logic [SEQ_W-1:0] stg_seq, a_seq_q, c_seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v    <= 1'b0;
         stg_kind <= EDGE_CLEAR;
         stg_sec  <= '0;
         stg_ns   <= '0;
         stg_seq  <= '0;
         a_seq_q  <= '0;
         c_seq_q  <= '0;
      end else begin
         stg_v <= rise | fall;
         if (rise | fall) begin
            stg_kind <= rise ? EDGE_ASSERT : EDGE_CLEAR;
            stg_sec  <= cor_sec;
            stg_ns   <= cor_ns;
            stg_seq  <= rise ? a_seq_q : c_seq_q;
         end
         if (rise) a_seq_q <= a_seq_q + SEQ_W'(1);
         if (fall) c_seq_q <= c_seq_q + SEQ_W'(1);
      end
   end

   // Stage 2: period statistics (R5, R6) and offset (R7)
   logic [SEC_W-1:0]  prev_sec;
   logic [NS_W-1:0]   prev_ns;
   logic [63:0]       prev_span, span, jit_full;
   logic [1:0]        seen_a;
   logic              is_a, d_ok, j_ok, lost_pend, fifo_full;
   logic [SEC_W-1:0]  dsec;
   logic [DELTA_W-1:0] d_val;
   logic [JIT_W-1:0]   j_val;
   logic [REC_W-1:0]   rec_in, rec_out;

   always_comb begin
      is_a     = (stg_kind == EDGE_ASSERT);
      dsec     = stg_sec - prev_sec;
      span     = 64'(dsec) * 64'(NS_PER_SEC) + 64'(stg_ns) - 64'(prev_ns);
      jit_full = span - prev_span;
      d_ok     = is_a && (seen_a != 2'd0);
      j_ok     = is_a && (seen_a == 2'd2);
      d_val    = d_ok ? span[DELTA_W-1:0] : '0;
      j_val    = j_ok ? jit_full[JIT_W-1:0] : '0;
      rec_in   = {lost_pend, is_a, stg_seq, stg_sec, stg_ns, d_val, d_ok,
                  j_val, j_ok, sec_offset(stg_ns)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sec  <= '0;
         prev_ns   <= '0;
         prev_span <= '0;
         seen_a    <= '0;
         lost_pend <= 1'b0;
      end else if (stg_v) begin
         if (is_a) begin
            prev_sec  <= stg_sec;
            prev_ns   <= stg_ns;
            prev_span <= span;
            if (seen_a != 2'd2) seen_a <= seen_a + 2'd1;
         end
         lost_pend <= fifo_full;   // R10: mark the next stored record
      end
   end

   ets_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(stg_v), .data_i(rec_in), .full_o(fifo_full),
      .valid_o(rec_valid_o), .ready_i(rec_ready_i), .data_o(rec_out));

   assign {rec_lost_o, rec_assert_o, rec_seq_o, rec_sec_o, rec_ns_o, rec_delta_o,
           rec_delta_ok_o, rec_jitter_o, rec_jitter_ok_o, rec_offset_o} = rec_out;

   localparam logic signed [OFF_W-1:0] HALF = OFF_W'(NS_PER_SEC / 2);

   a_r5_delta_on_assert: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && rec_delta_ok_o) |-> rec_assert_o);

   a_r6_jitter_needs_delta: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid_o && rec_jitter_ok_o) |-> rec_delta_ok_o);

   a_r7_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> (rec_offset_o >= -HALF) && (rec_offset_o < HALF));

   a_r2_frac_range: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> (rec_ns_o < NS_W'(NS_PER_SEC)));
endmodule

// File: tb/ets_capture_tb.sv
module ets_capture_tb;
   localparam longint INC   = 3_000_017;
   localparam int     HO    = 4;
   localparam int     DEPTH = 4;
   localparam longint BIL   = 1_000_000_000;
   localparam int     NV    = 10;
   // Stimulus table: low time before the rise, high time before the fall (cycles)
   localparam int PLO [NV] = '{10, 4, 3, 3, 60, 7, 150, 25, 200, 6};
   localparam int PHI [NV] = '{ 3, 3, 2, 2, 40, 7,  90,  5, 120, 6};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, evt, rdy;
   logic rec_valid, rec_assert, rec_dok, rec_jok, rec_lost;
   logic [15:0] rec_seq;
   logic [31:0] rec_sec;
   logic [29:0] rec_ns;
   logic [39:0] rec_delta;
   logic signed [31:0] rec_jit, rec_off;

   ets_capture #(.NS_INC(INC), .HOLDOFF(HO), .FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .rec_ready_i(rdy),
      .rec_valid_o(rec_valid), .rec_assert_o(rec_assert), .rec_seq_o(rec_seq),
      .rec_sec_o(rec_sec), .rec_ns_o(rec_ns), .rec_delta_o(rec_delta),
      .rec_delta_ok_o(rec_dok), .rec_jitter_o(rec_jit), .rec_jitter_ok_o(rec_jok),
      .rec_offset_o(rec_off), .rec_lost_o(rec_lost));

   longint cyc;
   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   typedef struct {
      bit a; longint seq, sec, ns, delta; bit dok; longint jit; bit jok; longint off; bit lost;
   } exp_t;
   exp_t eq [64];
   int wi = 0, ri = 0;
   longint m_aseq, m_cseq, m_prev_t, m_prev_d;
   int m_na;
   bit m_lost;
   int n_chk = 0, n_bad = 0;
   bit mon_en = 1'b0;

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_aseq = 0; m_cseq = 0; m_prev_t = 0; m_prev_d = 0; m_na = 0; m_lost = 0;
   endtask

   task automatic model(bit is_a, bit drop);
      exp_t e;
      longint t, d;
      t = cyc * INC;
      e.a = is_a; e.sec = t / BIL; e.ns = t % BIL;
      e.off = (e.ns >= BIL / 2) ? e.ns - BIL : e.ns;
      e.dok = 0; e.jok = 0; e.delta = 0; e.jit = 0; e.lost = 0;
      if (is_a) begin
         e.seq = m_aseq; m_aseq++;
         d = t - m_prev_t;
         if (m_na >= 1) begin e.dok = 1; e.delta = d; end
         if (m_na >= 2) begin e.jok = 1; e.jit = d - m_prev_d; end
         m_prev_t = t; m_prev_d = d;
         if (m_na < 2) m_na++;
      end else begin
         e.seq = m_cseq; m_cseq++;
      end
      if (drop) m_lost = 1;
      else begin
         e.lost = m_lost; m_lost = 0;
         eq[wi] = e; wi++;
      end
   endtask

   // gap: cycles since the previous change; acc: edge expected to be accepted
   task automatic edge_at(int gap, bit v, bit acc, bit drop);
      repeat (gap) @(negedge clk);
      evt = v;
      if (acc) model(v, drop);
   endtask

   task automatic compare_head();
      exp_t e;
      if (ri == wi) begin
         check("R9 unexpected record", 1, 0);
         return;
      end
      e = eq[ri]; ri++;
      check("R2 kind", rec_assert, e.a);
      check("R4 seq", rec_seq, e.seq);
      check("R3 seconds", rec_sec, e.sec);
      check("R2 fraction", rec_ns, e.ns);
      check("R5 delta", rec_delta, e.delta);
      check("R5 delta_ok", rec_dok, e.dok);
      check("R6 jitter", longint'(rec_jit), e.jit);
      check("R6 jitter_ok", rec_jok, e.jok);
      check("R7 offset", longint'(rec_off), e.off);
      check("R10 lost", rec_lost, e.lost);
   endtask

   initial begin
      forever begin
         @(negedge clk); #2;
         if (mon_en && rst_n && rec_valid && rdy) compare_head();
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] h_seq;
      logic [29:0] h_ns;
      rst_n = 1'b0; evt = 1'b0; rdy = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      #2 check("R1 no record in reset", rec_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      #2 check("R1 no record after reset", rec_valid, 0);
      mon_en = 1'b1;

      // Table walk: varied periods, boundary separations, second crossings
      for (int i = 0; i < NV; i++) begin
         edge_at(PLO[i], 1'b1, 1'b1, 1'b0);
         edge_at(PHI[i], 1'b0, 1'b1, 1'b0);
      end
      repeat (20) @(negedge clk);
      check("R9 table records drained", ri, wi);
      check("R3 run crossed two seconds", longint'(cyc * INC >= 2 * BIL), 1);

      // R8: holdoff boundary on both polarities
      edge_at(10, 1'b1, 1'b1, 1'b0);
      edge_at(2,  1'b0, 1'b1, 1'b0);
      edge_at(2,  1'b1, 1'b0, 1'b0);   // rise 4 cycles after accepted rise: ignored
      edge_at(3,  1'b0, 1'b1, 1'b0);   // fall 5 cycles after accepted fall: accepted
      edge_at(2,  1'b1, 1'b1, 1'b0);
      edge_at(8,  1'b0, 1'b1, 1'b0);
      edge_at(2,  1'b1, 1'b1, 1'b0);
      edge_at(2,  1'b0, 1'b0, 1'b0);   // fall 4 cycles after accepted fall: ignored
      edge_at(4,  1'b1, 1'b1, 1'b0);
      edge_at(4,  1'b0, 1'b1, 1'b0);
      repeat (20) @(negedge clk);
      check("R8 holdoff records drained", ri, wi);

      // R10: overflow against a stalled consumer
      rdy = 1'b0;
      edge_at(10, 1'b1, 1'b1, 1'b0);
      edge_at(6,  1'b0, 1'b1, 1'b0);
      edge_at(6,  1'b1, 1'b1, 1'b0);
      edge_at(6,  1'b0, 1'b1, 1'b0);
      edge_at(6,  1'b1, 1'b1, 1'b1);
      edge_at(6,  1'b0, 1'b1, 1'b1);
      repeat (5) @(negedge clk);
      #2 h_seq = rec_seq; h_ns = rec_ns;
      check("R9 valid under backpressure", rec_valid, 1);
      repeat (3) @(negedge clk);
      #2 check("R9 held seq", rec_seq, h_seq);
      check("R9 held fraction", rec_ns, h_ns);
      check("R9 still valid", rec_valid, 1);
      @(negedge clk); rdy = 1'b1;
      repeat (10) @(negedge clk);
      edge_at(10, 1'b1, 1'b1, 1'b0);
      edge_at(6,  1'b0, 1'b1, 1'b0);
      repeat (20) @(negedge clk);
      check("R10 overflow records drained", ri, wi);

      // R1: mid-run reset restarts time, sequence and statistics
      @(negedge clk); rst_n = 1'b0;
      model_reset();
      #2 check("R1 no record in second reset", rec_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      edge_at(10, 1'b1, 1'b1, 1'b0);
      edge_at(6,  1'b0, 1'b1, 1'b0);
      edge_at(9,  1'b1, 1'b1, 1'b0);
      edge_at(6,  1'b0, 1'b1, 1'b0);
      repeat (20) @(negedge clk);
      check("R1 post-reset records drained", ri, wi);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule